// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port driven from a simple single-cycle register bus. Software sets the value that each pin drives and chooses, pin by pin, whether the pin is an output. It reads the synchronized level of every pad. Every pin also has its own event detector. The detector can watch for a low level, a high level, a rising edge, a falling edge, or both edges.

A detected event sets a sticky status bit. Software clears that bit by writing 1 to it. A mask register decides which status bits reach the interrupt lines. There are two interrupt lines: one collects pins 0 to 15 and the other collects pins 16 to 31, so the two half-ports can go to different interrupt controller inputs. Pad inputs pass through a two-flop synchronizer. Edge detectors compare the newest synchronized sample with the sample one clock older.

The bus has no handshake. A write takes effect at the clock edge where `bus_wr_en` is high. Read data is a combinational function of `bus_addr`. Word offsets (bits [4:2]) pick the register. An access with bits [1:0] not zero writes nothing and reads zero.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, and after it is released, every register reads zero. `pad_oe`, `pad_out`, `irq_lo` and `irq_hi` are all low.
- R2: `pad_out` follows the output value register (offset 0x00). `pad_oe` follows the direction register (offset 0x04), where 1 means output. Reading offset 0x00 returns the value last written, whatever the pad level is.
- R3: Offset 0x08 reads `pad_in` through a two-flop synchronizer. A pad change made before clock edge k is still hidden after edge k and appears after edge k+1.
- R4: Each pin has a 2-bit trigger field. Pins 0-15 use the word at offset 0x0C and pins 16-31 use the word at offset 0x10. Pin n sits at bits [2*(n mod 16)+1 : 2*(n mod 16)]. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. An edge that does not match the field sets no status.
- R5: A level-triggered status bit sets again on every cycle its level holds. Clearing it has no lasting effect until the level goes away.
- R6: When a pin's bit in the both-edges register (offset 0x1C) is 1, both edges set that pin's status and its trigger field is ignored.
- R7: At offset 0x18, writing 1 to a status bit clears it and writing 0 leaves it unchanged. A status change caused by a pad change made before edge k is visible after edge k+2.
- R8: If a clearing write and a new event hit the same status bit in the same cycle, the bit stays set.
- R9: The mask register (offset 0x14) uses 1 to enable a pin. `irq_lo` is the OR of (status AND mask) over bits 0-15, and `irq_hi` is the same OR over bits 16-31.
- R10: Every writable register reads back at its offset: 0x00 output value, 0x04 direction, 0x0C and 0x10 trigger fields, 0x14 mask, 0x1C both-edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven onto the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
Software clearing a status bit and the detector setting that same bit can happen in the same cycle. The bench provokes this in two ways. First, it changes a pad before edge k and times a write of 1 to that status bit so it is captured at edge k+2, which is the edge where the rising-edge event is latched; the bit must read 1 afterwards. Second, it holds a high level on a pin and clears its status; the bit must read 1 again straight after the write. After that, an identical clear with no event pending must leave the bit at zero, which shows the surviving 1 came from the event and not from a write that was dropped.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger code held in each 2-bit per-pin field
    typedef enum logic [1:0] {
        TRG_LOW  = 2'b00,
        TRG_HIGH = 2'b01,
        TRG_RISE = 2'b10,
        TRG_FALL = 2'b11
    } trig_e;

    // Register chosen by word offset (byte address bits [4:2])
    typedef enum logic [2:0] {
        SEL_DOUT   = 3'd0,
        SEL_DIR    = 3'd1,
        SEL_PAD    = 3'd2,
        SEL_TRG_LO = 3'd3,
        SEL_TRG_HI = 3'd4,
        SEL_MASK   = 3'd5,
        SEL_STAT   = 3'd6,
        SEL_BOTH   = 3'd7
    } reg_sel_e;

    // One-cycle event decision for a single pin
    function automatic logic pin_event(trig_e trg, logic both, logic cur, logic prv);
        logic rise, fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        if (both) begin
            return rise | fall;
        end
        case (trg)
            TRG_LOW:  return ~cur;
            TRG_HIGH: return cur;
            TRG_RISE: return rise;
            default:  return fall;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

    // R3: second stage follows first stage one cycle later
    p_sync_stage_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sync_q == $past(meta_q)));

    // R3: the previous sample tracks the synchronized value one cycle later
    p_prev_stage_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prev_q == $past(sync_q)));

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] trg_lo_i,
    input  logic [NPIN-1:0] trg_hi_i,
    input  logic [NPIN-1:0] both_i,
    input  logic [NPIN-1:0] cur_i,
    input  logic [NPIN-1:0] prv_i,
    output logic [NPIN-1:0] evt_o
);
    localparam int HALF = NPIN / 2;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [1:0] field;
        if (i < HALF) begin : g_lo
            assign field = trg_lo_i[2*i +: 2];
        end else begin : g_hi
            assign field = trg_hi_i[2*(i-HALF) +: 2];
        end

        assign evt_o[i] = pin_event(trig_e'(field), both_i[i], cur_i[i], prv_i[i]);

        // R6: in both-edges mode a steady pin never raises an event
        p_both_quiet_r6: assert property (@(posedge clk) disable iff (rst)
            (both_i[i] && (cur_i[i] == prv_i[i])) |-> !evt_o[i]);
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] evt_i,
    input  logic [NPIN-1:0] clr_i,
    input  logic [NPIN-1:0] mask_i,
    output logic [NPIN-1:0] stat_o,
    output logic            irq_lo_o,
    output logic            irq_hi_o
);
    localparam int HALF = NPIN / 2;

    logic [NPIN-1:0] stat_q;
    logic [NPIN-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | evt_i;
        end
    end

    assign pend     = stat_q & mask_i;
    assign irq_lo_o = |pend[HALF-1:0];
    assign irq_hi_o = |pend[NPIN-1:HALF];
    assign stat_o   = stat_q;

    // R7: a cleared bit with no concurrent event reads zero next cycle
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(clr_i & ~evt_i)) == '0));

    // R8: an event always leaves its bit set, clear or not
    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R7: bits neither cleared nor hit keep their value
    p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(clr_i | evt_i)) == ($past(stat_q) & ~$past(clr_i | evt_i))));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [NPIN-1:0] dout_q, dir_q, trg_lo_q, trg_hi_q, mask_q, both_q;
    logic [NPIN-1:0] cur, prv, evt, stat, clr;
    reg_sel_e        sel;
    logic            aligned;
    logic            wr_ok;

    assign sel     = reg_sel_e'(bus_addr[4:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr_en && aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q   <= '0;
            dir_q    <= '0;
            trg_lo_q <= '0;
            trg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_DOUT:   dout_q   <= bus_wdata;
                SEL_DIR:    dir_q    <= bus_wdata;
                SEL_TRG_LO: trg_lo_q <= bus_wdata;
                SEL_TRG_HI: trg_hi_q <= bus_wdata;
                SEL_MASK:   mask_q   <= bus_wdata;
                SEL_BOTH:   both_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign clr = (wr_ok && sel == SEL_STAT) ? bus_wdata : '0;

    gpio_sync #(.W(NPIN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pad_in),
        .sync_o  (cur),
        .prev_o  (prv)
    );

    gpio_evt_detect #(.NPIN(NPIN)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .trg_lo_i (trg_lo_q),
        .trg_hi_i (trg_hi_q),
        .both_i   (both_q),
        .cur_i    (cur),
        .prv_i    (prv),
        .evt_o    (evt)
    );

    gpio_irq_status #(.NPIN(NPIN)) u_status (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .clr_i    (clr),
        .mask_i   (mask_q),
        .stat_o   (stat),
        .irq_lo_o (irq_lo),
        .irq_hi_o (irq_hi)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_DOUT:   bus_rdata = dout_q;
                SEL_DIR:    bus_rdata = dir_q;
                SEL_PAD:    bus_rdata = cur;
                SEL_TRG_LO: bus_rdata = trg_lo_q;
                SEL_TRG_HI: bus_rdata = trg_hi_q;
                SEL_MASK:   bus_rdata = mask_q;
                SEL_STAT:   bus_rdata = stat;
                default:    bus_rdata = both_q;
            endcase
        end
    end

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

    // R9: with every pin masked neither interrupt line may be high
    p_masked_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (!irq_lo && !irq_hi));

    // R2: output value changes only through a write to its offset
    p_dout_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && sel == SEL_DOUT) |=> $stable(dout_q));

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_lo;
    logic        irq_hi;

    int checks   = 0;
    int failures = 0;

    localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                           A_TLO = 5'h0C, A_THI = 5'h10, A_MASK = 5'h14,
                           A_STAT = 5'h18, A_BOTH = 5'h1C;
    localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

    always #4 clk = ~clk;

    gpio_irq_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // change pads at a falling edge, then wait past three rising edges
    task automatic pads(logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), d);
            check("R1 reg zero in reset", d, 32'h0);
        end
        check("R1 outputs in reset", {pad_oe[0], pad_out[0], irq_lo, irq_hi}, 32'h0);
    endtask

    task automatic t_data_dir();
        logic [31:0] d;
        wr(A_DOUT, 32'h1234_5678);
        wr(A_DIR, 32'hFFFF_0000);
        check("R2 pad_out", pad_out, 32'h1234_5678);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        rd(A_DOUT, d);
        check("R2 read value not pad", d, 32'h1234_5678);
        rd(A_DIR, d);
        check("R10 dir readback", d, 32'hFFFF_0000);
    endtask

    task automatic t_setup();
        logic [31:0] d;
        wr(A_TLO, ALL_RISE);
        wr(A_THI, ALL_RISE);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_TLO, d);
        check("R10 trig lo readback", d, ALL_RISE);
        rd(A_THI, d);
        check("R10 trig hi readback", d, ALL_RISE);
        rd(A_STAT, d);
        check("R7 status cleared", d, 32'h0);
    endtask

    task automatic t_pad_sync();
        logic [31:0] d;
        @(negedge clk);
        pad_in = 32'h00C0_0000;
        @(negedge clk);
        rd(A_PAD, d);
        check("R3 hidden after one edge", d, 32'h0);
        @(negedge clk);
        rd(A_PAD, d);
        check("R3 visible after two edges", d, 32'h00C0_0000);
        pads(32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise_mask();
        logic [31:0] d;
        pads(32'h0000_0008);
        rd(A_STAT, d);
        check("R4 rising pin3", d, 32'h0000_0008);
        check("R9 masked no irq", {irq_lo, irq_hi}, 32'h0);
        wr(A_MASK, 32'h0000_0008);
        rd(A_MASK, d);
        check("R10 mask readback", d, 32'h0000_0008);
        check("R9 irq_lo only", {irq_lo, irq_hi}, 32'h2);
        wr(A_STAT, 32'h0000_0008);
        check("R9 irq drops after clear", {irq_lo, irq_hi}, 32'h0);
        pads(32'h0);
        rd(A_STAT, d);
        check("R4 falling ignored on rise pin", d, 32'h0);
        wr(A_MASK, 32'h0);
    endtask

    task automatic t_fall_hi();
        logic [31:0] d;
        wr(A_THI, 32'hAAAA_ABAA);           // pin 20 -> code 11
        pads(32'h0010_0000);
        rd(A_STAT, d);
        check("R4 rise ignored on fall pin20", d, 32'h0);
        pads(32'h0);
        rd(A_STAT, d);
        check("R4 falling pin20", d, 32'h0010_0000);
        wr(A_MASK, 32'h0010_0000);
        check("R9 irq_hi only", {irq_lo, irq_hi}, 32'h1);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_MASK, 32'h0);
        wr(A_THI, ALL_RISE);
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(A_BOTH, 32'h0000_0020);
        rd(A_BOTH, d);
        check("R10 both readback", d, 32'h0000_0020);
        pads(32'h0000_0020);
        rd(A_STAT, d);
        check("R6 both rise", d, 32'h0000_0020);
        wr(A_STAT, 32'h0000_0020);
        pads(32'h0);
        rd(A_STAT, d);
        check("R6 both fall overrides field", d, 32'h0000_0020);
        wr(A_STAT, 32'h0000_0020);
        wr(A_BOTH, 32'h0);
        pads(32'h0000_0020);
        pads(32'h0);
        rd(A_STAT, d);
        check("R6 field back in force", d, 32'h0000_0020);
        wr(A_STAT, 32'hFFFF_FFFF);
        pads(32'h0000_0020);
        wr(A_STAT, 32'hFFFF_FFFF);
        pads(32'h0);
        rd(A_STAT, d);
        check("R6 fall ignored without both", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(A_TLO, 32'hAAAA_6AAA);           // pin 7 -> code 01
        pads(32'h0000_0080);
        wr(A_STAT, 32'h0000_0080);
        rd(A_STAT, d);
        check("R5 high level re-sets", d, 32'h0000_0080);
        pads(32'h0);
        wr(A_STAT, 32'h0000_0080);
        rd(A_STAT, d);
        check("R5 clear sticks once level gone", d, 32'h0);
        wr(A_TLO, 32'hAAAA_AAA8);           // pin 0 -> code 00
        @(negedge clk);
        rd(A_STAT, d);
        check("R4 low level pin0", d, 32'h0000_0001);
        wr(A_TLO, ALL_RISE);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c_zero();
        logic [31:0] d;
        pads(32'h0000_0008);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d);
        check("R7 write zero keeps", d, 32'h0000_0008);
        wr(A_STAT, 32'h0000_0004);
        rd(A_STAT, d);
        check("R7 other bit write keeps", d, 32'h0000_0008);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, d);
        check("R7 write one clears", d, 32'h0);
        pads(32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk);
        pad_in = 32'h0000_0008;              // before edge k
        @(negedge clk);                      // after edge k
        @(negedge clk);                      // after edge k+1
        bus_addr  = A_STAT;
        bus_wdata = 32'h0000_0008;
        bus_wr_en = 1'b1;                    // captured at edge k+2 with the event
        @(negedge clk);
        bus_wr_en = 1'b0;
        rd(A_STAT, d);
        check("R8 event wins over clear", d, 32'h0000_0008);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, d);
        check("R8 later clear works", d, 32'h0);
        pads(32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        bus_wr_en = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        pad_in    = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_data_dir();
        t_setup();
        t_pad_sync();
        t_rise_mask();
        t_fall_hi();
        t_both();
        t_level();
        t_w1c_zero();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule